// File: doc/BRIEF.md
# BCD Calendar Counter with Week Numbering

This block keeps wall-clock time and date as eight packed-BCD fields: seconds, minutes, hours, day of month, month, two-digit year, weekday and week number. A prescaler elsewhere supplies a 1 Hz enable and a 32 Hz enable. In normal operation each selected enable pulse advances the seconds. Carries then ripple up through the hours, the day (with month lengths and leap years), the month and the year. The weekday and the week number advance with each day change.

A load strobe copies all eight fields from a set port at once. Two control bits select test behaviour. One bit switches the counting rate to the 32 Hz enable. The other bit makes every field step at the same time with no carry between fields. This lets software drive each field through its full range quickly.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the fields read second 0x00, minute 0x00, hour 0x00, day 0x01, month 0x01, year 0x00, weekday 0x01, week 0x01.
- R2: When `load` is high at a clock edge, all eight fields take the `set_*` values on that edge. This holds even if an enable pulse is present in the same cycle.
- R3: The step enable is `tick_32hz` when `test_fast` is 1 and `tick_1hz` when it is 0. The enable that is not selected changes nothing, and no field changes on an edge without a step or a load.
- R4: In normal mode, seconds and minutes count 0x00 to 0x59 and hours count 0x00 to 0x23 in BCD. Each field wraps to 0x00 and carries into the next field when it passes its top value. A carry out of hours advances the day.
- R5: Months 0x04, 0x06, 0x09 and 0x11 end at day 0x30. Months 0x01, 0x03, 0x05, 0x07, 0x08, 0x10 and 0x12 end at day 0x31. Past the last day the day becomes 0x01 and the month advances.
- R6: February ends at day 0x29 when the decimal year is divisible by 4, with year 00 counted as leap. Otherwise February ends at day 0x28.
- R7: Month 0x12 wraps to 0x01 and advances the year. Year 0x99 wraps to 0x00.
- R8: The weekday counts 0x01 to 0x07 on each day change and wraps from 0x07 to 0x01. The week number advances only at that wrap.
- R9: When the weekday wraps while the week is 0x52, the week becomes 0x00 if the day being left is 0x25, 0x26 or 0x27 of month 0x12. Otherwise the week becomes 0x01. Below 0x52 the week simply increments.
- R10: A field holding an invalid BCD value or a value outside its range is cleared to its minimum value on its next increment. That clear does not carry into the next field.
- R11: With `test_par` set, each step increments all eight fields at once. Each field wraps on its own with no carry: the day wraps after 0x31, the week wraps from 0x52 to 0x00 and the weekday wraps from 0x07 to 0x01.
- R12: With both `test_par` and `test_fast` set, the parallel increment runs from `tick_32hz` and ignores `tick_1hz`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_1hz | input | 1 | One-second enable |
| tick_32hz | input | 1 | 32 Hz enable |
| test_fast | input | 1 | Selects the 32 Hz enable as the step |
| test_par | input | 1 | Parallel no-carry increment of all fields |
| load | input | 1 | Load all fields from the set port |
| set_sec | input | 8 | Seconds to load (BCD) |
| set_min | input | 8 | Minutes to load (BCD) |
| set_hour | input | 8 | Hours to load (BCD) |
| set_day | input | 8 | Day of month to load (BCD) |
| set_mon | input | 8 | Month to load (BCD) |
| set_year | input | 8 | Year to load (BCD) |
| set_wday | input | 8 | Weekday to load (BCD) |
| set_week | input | 8 | Week number to load (BCD) |
| sec | output | 8 | Seconds (BCD) |
| min | output | 8 | Minutes (BCD) |
| hour | output | 8 | Hours (BCD) |
| day | output | 8 | Day of month (BCD) |
| mon | output | 8 | Month (BCD) |
| year | output | 8 | Year (BCD) |
| wday | output | 8 | Weekday, 1 is Monday (BCD) |
| week | output | 8 | Week number (BCD) |

## Verification
The bench builds the block with its default `Y00_LEAP = 1`, so year 00 is treated as a leap year and a February 29 in year 00 can be reached. Each date boundary is reached through the set port, which places the counter one or two seconds before a rollover. This avoids counting through whole days. Year 0x10 is included to tell decimal leap detection apart from detection on the raw binary code. December dates on both sides of the 25–27 window check the year-end week rule.

// File: rtl/bcd_calendar.sv
module bcd_calendar #(
  parameter bit Y00_LEAP = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1hz,
  input  logic       tick_32hz,
  input  logic       test_fast,
  input  logic       test_par,
  input  logic       load,
  input  logic [7:0] set_sec,
  input  logic [7:0] set_min,
  input  logic [7:0] set_hour,
  input  logic [7:0] set_day,
  input  logic [7:0] set_mon,
  input  logic [7:0] set_year,
  input  logic [7:0] set_wday,
  input  logic [7:0] set_week,
  output logic [7:0] sec,
  output logic [7:0] min,
  output logic [7:0] hour,
  output logic [7:0] day,
  output logic [7:0] mon,
  output logic [7:0] year,
  output logic [7:0] wday,
  output logic [7:0] week
);

  function automatic logic [7:0] binc(input logic [7:0] v, input logic [7:0] lo, input logic [7:0] hi);
    logic ok;
    ok = (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9) && (v >= lo) && (v <= hi);
    if (!ok || v == hi)      return lo;
    else if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'h0};
    else                     return v + 8'd1;
  endfunction

  logic       step;
  logic [6:0] ybin;
  logic       leap;
  logic [7:0] mlen;
  logic       c_s, c_m, c_h, c_d, c_mo;
  logic [7:0] sec_n, min_n, hour_n, day_n, mon_n, year_n, wday_n, week_n;

  assign step = test_fast ? tick_32hz : tick_1hz;
  assign ybin = {year[7:4], 3'b000} + {2'b00, year[7:4], 1'b0} + {3'b000, year[3:0]};
  assign leap = (ybin[1:0] == 2'b00) && (Y00_LEAP || year != 8'h00);

  always_comb begin
    case (mon)
      8'h02:                      mlen = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: mlen = 8'h30;
      default:                    mlen = 8'h31;
    endcase
  end

  assign c_s  = sec == 8'h59;
  assign c_m  = c_s && min == 8'h59;
  assign c_h  = c_m && hour == 8'h23;
  assign c_d  = c_h && day == mlen;
  assign c_mo = c_d && mon == 8'h12;

  always_comb begin
    sec_n = sec; min_n = min; hour_n = hour; day_n = day;
    mon_n = mon; year_n = year; wday_n = wday; week_n = week;
    if (test_par) begin
      sec_n  = binc(sec,  8'h00, 8'h59);
      min_n  = binc(min,  8'h00, 8'h59);
      hour_n = binc(hour, 8'h00, 8'h23);
      day_n  = binc(day,  8'h01, 8'h31);
      mon_n  = binc(mon,  8'h01, 8'h12);
      year_n = binc(year, 8'h00, 8'h99);
      wday_n = binc(wday, 8'h01, 8'h07);
      week_n = binc(week, 8'h00, 8'h52);
    end else begin
      sec_n = binc(sec, 8'h00, 8'h59);
      if (c_s) min_n  = binc(min,  8'h00, 8'h59);
      if (c_m) hour_n = binc(hour, 8'h00, 8'h23);
      if (c_h) begin
        day_n  = binc(day,  8'h01, mlen);
        wday_n = binc(wday, 8'h01, 8'h07);
        if (wday == 8'h07) begin
          if (week == 8'h52)
            week_n = (mon == 8'h12 && (day == 8'h25 || day == 8'h26 || day == 8'h27)) ? 8'h00 : 8'h01;
          else
            week_n = binc(week, 8'h00, 8'h52);
        end
      end
      if (c_d)  mon_n  = binc(mon,  8'h01, 8'h12);
      if (c_mo) year_n = binc(year, 8'h00, 8'h99);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec <= 8'h00; min <= 8'h00; hour <= 8'h00; day <= 8'h01;
      mon <= 8'h01; year <= 8'h00; wday <= 8'h01; week <= 8'h01;
    end else if (load) begin
      sec <= set_sec; min <= set_min; hour <= set_hour; day <= set_day;
      mon <= set_mon; year <= set_year; wday <= set_wday; week <= set_week;
    end else if (step) begin
      sec <= sec_n; min <= min_n; hour <= hour_n; day <= day_n;
      mon <= mon_n; year <= year_n; wday <= wday_n; week <= week_n;
    end
  end

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> {sec, min, hour, day, mon, year, wday, week} ==
             $past({set_sec, set_min, set_hour, set_day, set_mon, set_year, set_wday, set_week}));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !(test_fast ? tick_32hz : tick_1hz)) |=> $stable({sec, min, hour, day, mon, year, wday, week}));

  assert_sec_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !test_par && sec == 8'h59) |=> sec == 8'h00);

  assert_week_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !test_par && !(wday == 8'h07 && hour == 8'h23 && min == 8'h59 && sec == 8'h59)) |=> $stable(week));

  assert_par_all_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && test_par) |=> (sec != $past(sec)) && (min != $past(min)) && (hour != $past(hour)) &&
      (day != $past(day)) && (mon != $past(mon)) && (year != $past(year)) &&
      (wday != $past(wday)) && (week != $past(week)));

endmodule

// File: tb/sim_bcd_calendar.sv
module sim_bcd_calendar;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_1hz = 1'b0, tick_32hz = 1'b0, test_fast = 1'b0, test_par = 1'b0, load = 1'b0;
  logic [63:0] sv = '0;
  logic [7:0] sec, min, hour, day, mon, year, wday, week;
  int checks = 0, failures = 0, cyc = 0;

  always #5 clk = ~clk;

  bcd_calendar u0 (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .tick_32hz(tick_32hz),
    .test_fast(test_fast), .test_par(test_par), .load(load),
    .set_sec(sv[63:56]), .set_min(sv[55:48]), .set_hour(sv[47:40]), .set_day(sv[39:32]),
    .set_mon(sv[31:24]), .set_year(sv[23:16]), .set_wday(sv[15:8]), .set_week(sv[7:0]),
    .sec(sec), .min(min), .hour(hour), .day(day), .mon(mon), .year(year), .wday(wday), .week(week));

  wire [63:0] now = {sec, min, hour, day, mon, year, wday, week};

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      failures = failures + 1;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ld(input logic [63:0] v);
    @(negedge clk); sv = v; load = 1'b1;
    @(negedge clk); load = 1'b0;
  endtask

  task automatic slow(input int n);
    @(negedge clk); tick_1hz = 1'b1;
    repeat (n) @(negedge clk);
    tick_1hz = 1'b0;
  endtask

  task automatic fast(input int n);
    @(negedge clk); tick_32hz = 1'b1;
    repeat (n) @(negedge clk);
    tick_32hz = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 reset", now, 64'h00_00_00_01_01_00_01_01);
  endtask

  task automatic t_load;
    ld(64'h56_34_12_15_06_24_03_22);
    chk("R2 load", now, 64'h56_34_12_15_06_24_03_22);
    @(negedge clk); sv = 64'h10_20_05_09_03_11_02_10; load = 1'b1; tick_1hz = 1'b1;
    @(negedge clk); load = 1'b0; tick_1hz = 1'b0;
    chk("R2 load over tick", now, 64'h10_20_05_09_03_11_02_10);
  endtask

  task automatic t_rate;
    ld(64'h10_00_00_01_01_21_01_01);
    fast(3);
    chk("R3 32hz ignored in normal rate", now, 64'h10_00_00_01_01_21_01_01);
    test_fast = 1'b1;
    slow(3);
    chk("R3 1hz ignored in fast rate", now, 64'h10_00_00_01_01_21_01_01);
    fast(3);
    chk("R3 fast rate counts", now, 64'h13_00_00_01_01_21_01_01);
    test_fast = 1'b0;
  endtask

  task automatic t_chain;
    ld(64'h58_59_23_10_03_21_03_10);
    slow(2);
    chk("R4 carry to day", now, 64'h00_00_00_11_03_21_04_10);
    ld(64'h59_59_09_10_03_21_03_10);
    slow(1);
    chk("R4 minute carry", now, 64'h00_00_10_10_03_21_03_10);
  endtask

  task automatic t_months;
    ld(64'h59_59_23_30_04_21_02_10);
    slow(1);
    chk("R5 april end", now, 64'h00_00_00_01_05_21_03_10);
    ld(64'h59_59_23_30_01_21_02_10);
    slow(1);
    chk("R5 january 31", now, 64'h00_00_00_31_01_21_03_10);
    slow(86400 - 86399 + 0);
    chk("R5 31-day tick", now, 64'h01_00_00_31_01_21_03_10);
    ld(64'h59_59_23_31_01_21_02_10);
    slow(1);
    chk("R5 january end", now, 64'h00_00_00_01_02_21_03_10);
  endtask

  task automatic t_leap;
    ld(64'h59_59_23_28_02_24_02_10);
    slow(1);
    chk("R6 leap 24", now, 64'h00_00_00_29_02_24_03_10);
    ld(64'h59_59_23_28_02_23_02_10);
    slow(1);
    chk("R6 non-leap 23", now, 64'h00_00_00_01_03_23_03_10);
    ld(64'h59_59_23_28_02_00_02_10);
    slow(1);
    chk("R6 leap 00", now, 64'h00_00_00_29_02_00_03_10);
    ld(64'h59_59_23_28_02_10_02_10);
    slow(1);
    chk("R6 non-leap 10", now, 64'h00_00_00_01_03_10_03_10);
    ld(64'h59_59_23_29_02_24_02_10);
    slow(1);
    chk("R6 leap end", now, 64'h00_00_00_01_03_24_03_10);
  endtask

  task automatic t_year;
    ld(64'h59_59_23_31_12_99_03_40);
    slow(1);
    chk("R7 year wrap", now, 64'h00_00_00_01_01_00_04_40);
    ld(64'h59_59_23_31_12_41_03_40);
    slow(1);
    chk("R7 year step", now, 64'h00_00_00_01_01_42_04_40);
  endtask

  task automatic t_week;
    ld(64'h59_59_23_12_05_21_07_20);
    slow(1);
    chk("R8 week advance", now, 64'h00_00_00_13_05_21_01_21);
    ld(64'h59_59_23_12_05_21_05_20);
    slow(1);
    chk("R8 week held", now, 64'h00_00_00_13_05_21_06_20);
    ld(64'h59_59_23_26_12_21_07_52);
    slow(1);
    chk("R9 dec 26", now, 64'h00_00_00_27_12_21_01_00);
    ld(64'h59_59_23_25_12_21_07_52);
    slow(1);
    chk("R9 dec 25", now, 64'h00_00_00_26_12_21_01_00);
    ld(64'h59_59_23_28_12_21_07_52);
    slow(1);
    chk("R9 dec 28", now, 64'h00_00_00_29_12_21_01_01);
    ld(64'h59_59_23_24_12_21_07_52);
    slow(1);
    chk("R9 dec 24", now, 64'h00_00_00_25_12_21_01_01);
  endtask

  task automatic t_range;
    ld(64'h75_10_05_05_05_21_02_10);
    slow(1);
    chk("R10 bad seconds", now, 64'h00_10_05_05_05_21_02_10);
    ld(64'h59_59_24_05_05_21_02_10);
    slow(1);
    chk("R10 bad hours", now, 64'h00_00_00_05_05_21_02_10);
    ld(64'h59_59_23_05_05_21_09_10);
    slow(1);
    chk("R10 bad weekday", now, 64'h00_00_00_06_05_21_01_10);
    ld(64'h59_59_23_31_04_21_02_10);
    slow(1);
    chk("R10 april 31", now, 64'h00_00_00_01_04_21_03_10);
  endtask

  task automatic t_par;
    test_par = 1'b1;
    ld(64'h59_59_23_31_12_99_07_52);
    slow(1);
    chk("R11 parallel wrap", now, 64'h00_00_00_01_01_00_01_00);
    ld(64'h10_20_05_15_06_40_03_30);
    slow(2);
    chk("R11 parallel step", now, 64'h12_22_07_17_08_42_05_32);
    ld(64'h29_59_09_30_02_19_06_09);
    slow(1);
    chk("R11 no carry", now, 64'h30_00_10_31_03_20_07_10);
    test_fast = 1'b1;
    ld(64'h10_20_05_15_06_40_03_30);
    slow(2);
    chk("R12 1hz ignored", now, 64'h10_20_05_15_06_40_03_30);
    fast(3);
    chk("R12 parallel fast", now, 64'h13_23_08_18_09_43_06_33);
    test_fast = 1'b0;
    test_par = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_load;
    t_rate;
    t_chain;
    t_months;
    t_leap;
    t_year;
    t_week;
    t_range;
    t_par;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule